// File: doc/BRIEF.md
# Sprite Page Copy DMA Engine

This engine copies one full page of CPU address space into the sprite attribute memory. It does not write that memory directly. Every byte goes out as a bus write to a fixed sink register address. Software starts a copy by writing a page number to the trigger address. The engine then takes over the memory bus and holds the CPU suspended until the last byte has been written.

After a short alignment preamble, the engine alternates read and write cycles. Each read fetches the next source byte from `page * PAGE_BYTES + i`, and the following write stores that byte to the sink address. The preamble is one dummy read cycle. One more dummy read is added when the free-running cycle parity is odd in the trigger cycle. A live count of the bytes still to be copied is exported, so that other DMA arbitration logic can see how far the copy has progressed. The CPU also uses the hold output to freeze its interrupt polling.

Top module: `spr_dma_engine`

## Requirements
- R1: After reset, `cpu_hold`, `mem_rd` and `mem_wr` are low and `bytes_left` is 0.
- R2: A write with `cpu_wr_addr` equal to 0x4014 while `cpu_hold` is low starts a copy. `cpu_hold` is high from the next cycle on, and the source base is the written byte times 256.
- R3: A CPU write to any address other than 0x4014 starts nothing.
- R4: The preamble consists of dummy reads at the source base address. There is one such read when `cyc_odd` is 0 in the trigger cycle and two when it is 1. `bytes_left` stays 0 during the preamble.
- R5: After the preamble come 256 pairs, for i from 0 up to 255. Each pair is a read of base+i followed in the next cycle by a write of the byte read to address 0x2004.
- R6: `cpu_hold` stays high for exactly 513 cycles (even parity) or 514 cycles (odd parity). It falls in the cycle after the last write.
- R7: `bytes_left` shows 256−i during both cycles of pair i. It returns to 0 after the last write.
- R8: A trigger write that arrives while `cpu_hold` is high is ignored. This includes a trigger in the cycle of the final write. Neither the source page nor the length of the copy changes.
- R9: A trigger write in the first cycle after `cpu_hold` falls is accepted.
- R10: `mem_rd` and `mem_wr` are never high together, and both are low whenever `cpu_hold` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | CPU write strobe |
| cpu_wr_addr | input | 16 | CPU write address |
| cpu_wr_data | input | 8 | CPU write data (page number on a trigger) |
| cyc_odd | input | 1 | Free-running cycle parity, 1 on odd cycles |
| mem_addr | output | 16 | Bus master address |
| mem_rd | output | 1 | Bus master read strobe |
| mem_wr | output | 1 | Bus master write strobe |
| mem_wdata | output | 8 | Bus master write data |
| mem_rdata | input | 8 | Read data, valid in the cycle of the read |
| cpu_hold | output | 1 | CPU suspend, high for the whole copy |
| bytes_left | output | 9 | Bytes still to be written |

## Verification
There are two points where a new trigger meets the end of a copy. The first is a trigger in the very cycle of the final sink write, while the engine is still busy. The second is a trigger in the cycle right after hold falls. The bench waits for the write cycle that shows one byte left and drives a trigger carrying a foreign page there. It then drives a second trigger one cycle later. The scoreboard must show that the first trigger produced no bus traffic and that hold dropped for exactly one cycle. It must also show that the second trigger began a complete copy of its own page, with the preamble length set by the parity in that cycle.

// File: rtl/spr_dma_pkg.sv
package spr_dma_pkg;

   // Phases of one page copy, in the order they occur.
   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_ALIGN  = 3'd1,   // extra dummy read taken on odd parity
      PH_SETTLE = 3'd2,   // dummy read taken on every copy
      PH_FETCH  = 3'd3,   // source read
      PH_STORE  = 3'd4    // sink write
   } dma_phase_e;

endpackage

// File: rtl/spr_dma_trigger.sv
module spr_dma_trigger #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned TRIG_ADDR = 'h4014
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              engine_busy,
   output logic              start,
   output logic [DATA_W-1:0] page
);

   localparam logic [ADDR_W-1:0] TRIG = ADDR_W'(TRIG_ADDR);

   // A trigger counts only when no copy is in flight.
   always_comb begin
      start = wr_en && (wr_addr == TRIG) && !engine_busy;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page <= '0;
      end else if (start) begin
         page <= wr_data;
      end
   end

endmodule

// File: rtl/spr_dma_fsm.sv
module spr_dma_fsm
   import spr_dma_pkg::*;
#(
   parameter bit ALIGN_ON_PARITY = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       cyc_odd,
   input  logic       last_byte,
   output dma_phase_e phase
);

   logic       want_align;
   dma_phase_e phase_nxt;

   generate
      if (ALIGN_ON_PARITY) begin : g_parity
         assign want_align = cyc_odd;
      end else begin : g_fixed
         assign want_align = 1'b0;
      end
   endgenerate

   always_comb begin
      phase_nxt = phase;
      unique case (phase)
         PH_IDLE:   if (start) phase_nxt = want_align ? PH_ALIGN : PH_SETTLE;
         PH_ALIGN:  phase_nxt = PH_SETTLE;
         PH_SETTLE: phase_nxt = PH_FETCH;
         PH_FETCH:  phase_nxt = PH_STORE;
         PH_STORE:  phase_nxt = last_byte ? PH_IDLE : PH_FETCH;
         default:   phase_nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
      end else begin
         phase <= phase_nxt;
      end
   end

endmodule

// File: rtl/spr_dma_count.sv
module spr_dma_count #(
   parameter int unsigned PAGE_BYTES = 256,
   parameter int unsigned PAGE_SHIFT = 8,
   parameter int unsigned CNT_W      = 9
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic                  step,
   output logic [CNT_W-1:0]      cnt,
   output logic [PAGE_SHIFT-1:0] idx,
   output logic                  last_byte
);

   localparam logic [CNT_W-1:0] FULL = CNT_W'(PAGE_BYTES);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= FULL;
      end else if (step && (cnt != '0)) begin
         cnt <= cnt - ONE;
      end
   end

   // The offset inside the page follows from how many bytes remain.
   logic [CNT_W-1:0] done_cnt;
   always_comb begin
      done_cnt  = FULL - cnt;
      idx       = done_cnt[PAGE_SHIFT-1:0];
      last_byte = (cnt == ONE);
   end

endmodule

// File: rtl/spr_dma_bus.sv
module spr_dma_bus
   import spr_dma_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned PAGE_SHIFT = 8,
   parameter int unsigned SINK_ADDR  = 'h2004
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  dma_phase_e            phase,
   input  logic [DATA_W-1:0]     page,
   input  logic [PAGE_SHIFT-1:0] idx,
   input  logic [DATA_W-1:0]     rdata,
   output logic [ADDR_W-1:0]     addr,
   output logic                  rd,
   output logic                  wr,
   output logic [DATA_W-1:0]     wdata
);

   localparam logic [ADDR_W-1:0] SINK  = ADDR_W'(SINK_ADDR);
   localparam int unsigned       SRC_W = DATA_W + PAGE_SHIFT;

   logic [ADDR_W-1:0] base_addr;
   logic [ADDR_W-1:0] src_addr;
   logic [DATA_W-1:0] held;

   // Widen the page/offset pair to the bus width only when there is room.
   generate
      if (ADDR_W > SRC_W) begin : g_pad
         assign base_addr = {{(ADDR_W-SRC_W){1'b0}}, page, {PAGE_SHIFT{1'b0}}};
         assign src_addr  = {{(ADDR_W-SRC_W){1'b0}}, page, idx};
      end else begin : g_exact
         assign base_addr = {page, {PAGE_SHIFT{1'b0}}};
         assign src_addr  = {page, idx};
      end
   endgenerate

   always_comb begin
      addr = '0;
      rd   = 1'b0;
      wr   = 1'b0;
      unique case (phase)
         PH_ALIGN, PH_SETTLE: begin
            addr = base_addr;
            rd   = 1'b1;
         end
         PH_FETCH: begin
            addr = src_addr;
            rd   = 1'b1;
         end
         PH_STORE: begin
            addr = SINK;
            wr   = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held <= '0;
      end else if (phase == PH_FETCH) begin
         held <= rdata;
      end
   end

   assign wdata = held;

endmodule

// File: rtl/spr_dma_engine.sv
module spr_dma_engine
   import spr_dma_pkg::*;
#(
   parameter int unsigned ADDR_W          = 16,
   parameter int unsigned DATA_W          = 8,
   parameter int unsigned PAGE_BYTES      = 256,
   parameter int unsigned TRIG_ADDR       = 'h4014,
   parameter int unsigned SINK_ADDR       = 'h2004,
   parameter bit          ALIGN_ON_PARITY = 1'b1,
   localparam int unsigned PAGE_SHIFT     = $clog2(PAGE_BYTES),
   localparam int unsigned CNT_W          = PAGE_SHIFT + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr_en,
   input  logic [ADDR_W-1:0] cpu_wr_addr,
   input  logic [DATA_W-1:0] cpu_wr_data,
   input  logic              cyc_odd,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              cpu_hold,
   output logic [CNT_W-1:0]  bytes_left
);

   // Elaboration-time parameter checks.
   generate
      if (PAGE_BYTES < 2 || (1 << PAGE_SHIFT) != PAGE_BYTES) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two of at least 2");
      end
      if (DATA_W + PAGE_SHIFT > ADDR_W) begin : g_bad_width
         $error("page number and offset do not fit in ADDR_W");
      end
      if (ADDR_W < 32 && (TRIG_ADDR >> ADDR_W) != 0) begin : g_bad_trig
         $error("TRIG_ADDR exceeds the address width");
      end
      if (ADDR_W < 32 && (SINK_ADDR >> ADDR_W) != 0) begin : g_bad_sink
         $error("SINK_ADDR exceeds the address width");
      end
   endgenerate

   dma_phase_e            phase;
   logic                  start;
   logic [DATA_W-1:0]     page;
   logic [PAGE_SHIFT-1:0] idx;
   logic                  last_byte;
   logic                  busy;

   assign busy = (phase != PH_IDLE);

   spr_dma_trigger #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .TRIG_ADDR(TRIG_ADDR)
   ) u_trig (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (cpu_wr_en),
      .wr_addr    (cpu_wr_addr),
      .wr_data    (cpu_wr_data),
      .engine_busy(busy),
      .start      (start),
      .page       (page)
   );

   spr_dma_fsm #(
      .ALIGN_ON_PARITY(ALIGN_ON_PARITY)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .cyc_odd  (cyc_odd),
      .last_byte(last_byte),
      .phase    (phase)
   );

   spr_dma_count #(
      .PAGE_BYTES(PAGE_BYTES),
      .PAGE_SHIFT(PAGE_SHIFT),
      .CNT_W     (CNT_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (phase == PH_SETTLE),
      .step     (phase == PH_STORE),
      .cnt      (bytes_left),
      .idx      (idx),
      .last_byte(last_byte)
   );

   spr_dma_bus #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .PAGE_SHIFT(PAGE_SHIFT),
      .SINK_ADDR (SINK_ADDR)
   ) u_bus (
      .clk  (clk),
      .rst_n(rst_n),
      .phase(phase),
      .page (page),
      .idx  (idx),
      .rdata(mem_rdata),
      .addr (mem_addr),
      .rd   (mem_rd),
      .wr   (mem_wr),
      .wdata(mem_wdata)
   );

   assign cpu_hold = busy;

endmodule

// File: rtl/spr_dma_engine_chk.sv
module spr_dma_engine_chk #(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned PAGE_BYTES = 256,
   parameter int unsigned CNT_W      = 9,
   parameter int unsigned TRIG_ADDR  = 'h4014,
   parameter int unsigned SINK_ADDR  = 'h2004
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_wr_en,
   input logic [ADDR_W-1:0] cpu_wr_addr,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic              cpu_hold,
   input logic [CNT_W-1:0]  bytes_left
);

   localparam logic [ADDR_W-1:0] TRIG = ADDR_W'(TRIG_ADDR);
   localparam logic [ADDR_W-1:0] SINK = ADDR_W'(SINK_ADDR);
   localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0]  FULL = CNT_W'(PAGE_BYTES);

   a_r10_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_hold |-> (!mem_rd && !mem_wr));

   a_r2_hold_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr_en && cpu_wr_addr == TRIG && !cpu_hold) |=> cpu_hold);

   a_r4_preamble_read: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_hold) |-> (mem_rd && bytes_left == '0));

   a_r5_read_then_sink: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && bytes_left != '0) |=>
         (mem_wr && mem_addr == SINK && bytes_left == $past(bytes_left)));

   a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && bytes_left > ONE) |=>
         (mem_rd && bytes_left == $past(bytes_left) - ONE));

   a_r6_ends_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_hold) |-> ($past(mem_wr) && $past(bytes_left) == ONE));

   a_r7_count_range: assert property (@(posedge clk) disable iff (!rst_n)
      bytes_left <= FULL);

endmodule

bind spr_dma_engine spr_dma_engine_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .PAGE_BYTES(PAGE_BYTES),
   .CNT_W     (CNT_W),
   .TRIG_ADDR (TRIG_ADDR),
   .SINK_ADDR (SINK_ADDR)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_wr_en  (cpu_wr_en),
   .cpu_wr_addr(cpu_wr_addr),
   .mem_addr   (mem_addr),
   .mem_rd     (mem_rd),
   .mem_wr     (mem_wr),
   .cpu_hold   (cpu_hold),
   .bytes_left (bytes_left)
);

// File: tb/spr_dma_engine_test.sv
module spr_dma_engine_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_wr_en = 1'b0;
   logic [15:0] cpu_wr_addr = '0;
   logic [7:0]  cpu_wr_data = '0;
   logic        cyc_odd = 1'b0;
   logic [15:0] mem_addr;
   logic        mem_rd;
   logic        mem_wr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata;
   logic        cpu_hold;
   logic [8:0]  bytes_left;

   int n_chk  = 0;
   int n_fail = 0;

   typedef struct packed {
      logic        is_wr;
      logic        is_dummy;
      logic [15:0] addr;
      logic [7:0]  data;
      logic [8:0]  cnt;
   } op_t;

   op_t exp_q[$];
   int  hold_q[$];

   always #4 clk = ~clk;   // 125 MHz

   spr_dma_engine uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpu_wr_en  (cpu_wr_en),
      .cpu_wr_addr(cpu_wr_addr),
      .cpu_wr_data(cpu_wr_data),
      .cyc_odd    (cyc_odd),
      .mem_addr   (mem_addr),
      .mem_rd     (mem_rd),
      .mem_wr     (mem_wr),
      .mem_wdata  (mem_wdata),
      .mem_rdata  (mem_rdata),
      .cpu_hold   (cpu_hold),
      .bytes_left (bytes_left)
   );

   function automatic logic [7:0] mem_fn(logic [15:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
   endfunction

   assign mem_rdata = mem_fn(mem_addr);

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Free-running parity, updated just after each rising edge.
   initial begin
      forever begin
         @(posedge clk);
         #1 cyc_odd = ~cyc_odd;
      end
   end

   // Called at rising edge + 2; drives one write cycle, returns one edge later.
   task automatic drive_now(logic [15:0] a, logic [7:0] pg, bit expect_start);
      bit odd;
      odd = cyc_odd;
      cpu_wr_en   = 1'b1;
      cpu_wr_addr = a;
      cpu_wr_data = pg;
      if (expect_start) begin
         logic [15:0] base;
         base = {pg, 8'h00};
         for (int d = 0; d < (odd ? 2 : 1); d++)
            exp_q.push_back('{1'b0, 1'b1, base, 8'h00, 9'd0});
         for (int i = 0; i < 256; i++) begin
            logic [15:0] src;
            src = base + 16'(i);
            exp_q.push_back('{1'b0, 1'b0, src, 8'h00, 9'(256 - i)});
            exp_q.push_back('{1'b1, 1'b0, 16'h2004, mem_fn(src), 9'(256 - i)});
         end
         hold_q.push_back(odd ? 514 : 513);
      end
      @(posedge clk);
      #2;
      cpu_wr_en = 1'b0;
      if (expect_start) begin
         chk(cpu_hold == 1'b1, "R2", "hold after trigger", cpu_hold, 1);
         chk(bytes_left == 9'd0, "R4", "count in preamble", bytes_left, 0);
      end
   endtask

   task automatic fire(logic [15:0] a, logic [7:0] pg, int want_odd, bit expect_start);
      @(posedge clk);
      #2;
      if (want_odd >= 0 && cyc_odd != want_odd[0]) begin
         @(posedge clk);
         #2;
      end
      drive_now(a, pg, expect_start);
   endtask

   task automatic wait_idle();
      do begin
         @(posedge clk);
         #2;
      end while (cpu_hold);
   endtask

   // Monitor / scoreboard.
   initial begin
      int run;
      run = 0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (mem_rd || mem_wr) begin
               chk(!(mem_rd && mem_wr), "R10", "rd and wr together", 1, 0);
               chk(cpu_hold, "R10", "bus op without hold", cpu_hold, 1);
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R8", "unexpected bus op at addr", mem_addr, 0);
               end else begin
                  op_t e;
                  e = exp_q.pop_front();
                  chk(mem_wr == e.is_wr, e.is_dummy ? "R4" : "R5", "op kind",
                      mem_wr, e.is_wr);
                  chk(mem_addr == e.addr, e.is_dummy ? "R4" : "R5", "address",
                      mem_addr, e.addr);
                  if (e.is_wr)
                     chk(mem_wdata == e.data, "R5", "sink data", mem_wdata, e.data);
                  chk(bytes_left == e.cnt, "R7", "bytes_left", bytes_left, e.cnt);
               end
            end
            if (cpu_hold) begin
               run++;
            end else if (run > 0) begin
               if (hold_q.size() == 0) begin
                  chk(1'b0, "R6", "unexpected hold length", run, 0);
               end else begin
                  int e;
                  e = hold_q.pop_front();
                  chk(run == e, "R6", "hold length", run, e);
               end
               chk(bytes_left == 9'd0, "R7", "count after copy", bytes_left, 0);
               run = 0;
            end
         end
      end
   end

   initial begin
      fork
         begin
            repeat (4) @(posedge clk);
            #2 rst_n = 1'b1;
            @(negedge clk);
            chk(!cpu_hold, "R1", "hold at reset", cpu_hold, 0);
            chk(!mem_rd && !mem_wr, "R1", "bus at reset", {mem_rd, mem_wr}, 0);
            chk(bytes_left == 9'd0, "R1", "count at reset", bytes_left, 0);

            // R3: other addresses do nothing.
            fire(16'h4015, 8'h03, -1, 1'b0);
            fire(16'h2004, 8'h04, -1, 1'b0);
            fire(16'h0014, 8'h05, -1, 1'b0);
            repeat (6) @(posedge clk);
            #2;
            chk(!cpu_hold, "R3", "hold after foreign write", cpu_hold, 0);

            // Even-parity copy with an ignored trigger in the middle (R8).
            fire(16'h4014, 8'h02, 0, 1'b1);
            repeat (100) @(posedge clk);
            #2;
            drive_now(16'h4014, 8'h7F, 1'b0);
            wait_idle();

            // Odd-parity copy.
            fire(16'h4014, 8'hC1, 1, 1'b1);
            wait_idle();

            // Top page; trigger during final write (R8), then right after (R9).
            fire(16'h4014, 8'hFF, 0, 1'b1);
            do begin
               @(posedge clk);
               #2;
            end while (!(mem_wr && bytes_left == 9'd1));
            drive_now(16'h4014, 8'h10, 1'b0);
            chk(!cpu_hold, "R8", "hold after trigger in last write", cpu_hold, 0);
            drive_now(16'h4014, 8'h33, 1'b1);   // R9
            wait_idle();

            repeat (4) @(posedge clk);
            #2;
            chk(exp_q.size() == 0, "R5", "items left in scoreboard", exp_q.size(), 0);
            chk(hold_q.size() == 0, "R6", "hold lengths left", hold_q.size(), 0);
         end
         begin
            repeat (20000) @(posedge clk);
            chk(1'b0, "R6", "watchdog expired", 0, 1);
         end
      join_any
      disable fork;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule